// File: doc/BRIEF.md
# Four-Level Interrupt Priority Arbiter

This block decides which of five interrupt sources the processor core should service next. Each source has a request line, an individual enable bit and a two-bit priority level. A request is considered only while both the global enable and its own enable are set. Among the eligible requests, the arbiter selects the one at the highest level. It then compares that level with the levels already being serviced, and offers the request to the core only when it may legally preempt the running handler.

The core acknowledges an offered request with a one-cycle strobe. That marks the granted level as in service. A return strobe at the end of a handler clears the highest in-service level, which lets requests at that level compete again. The enables and the two priority registers are written through a small write-only register bus. The outputs are combinational from the registered state and the request inputs. The request flags, the pin edge/level detection and the vector fetch are outside this block.

Top module: `irqArbiter`

## Requirements
- R1: Source s is requested on `irqReq[s]`, with bit 0 = external interrupt 0, bit 1 = timer 0, bit 2 = external interrupt 1, bit 3 = timer 1 and bit 4 = serial port. A grant drives `irqVector` with that bit index (0 to 4).
- R2: The level of source s is {high bit, low bit}. The high bit is bit s of the register at address 2 and the low bit is bit s of the register at address 1. `irqLevel` shows the granted level (0 lowest, 3 highest).
- R3: While levels are in service, a request is offered only if its level is strictly above the highest in-service level. A request at the same level or lower is held back.
- R4: While level 3 is in service, `irqValid` stays low whatever the requests are.
- R5: When eligible requests at different levels are present in the same cycle, the higher level is offered.
- R6: After reset, both priority registers, all enables and the in-service set are zero, so no request is offered.
- R7: Source s is eligible only when bit 7 (global enable) and bit s of the register at address 0 are both 1.
- R8: `irqAck` high while `irqValid` is high marks `irqLevel` as in service from the next cycle. `retStrobe` clears the highest in-service level and has no effect when none is in service.
- R9: Among eligible requests at the same level, the lowest bit index (order INT0, timer 0, INT1, timer 1, serial) wins.
- R10: `irqAck` while `irqValid` is low, and writes to address 3, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address (0 enable, 1 level low, 2 level high) |
| busWrData | input | 8 | Register write data |
| irqReq | input | 5 | Request lines, one per source |
| irqAck | input | 1 | Core accepts the offered interrupt |
| retStrobe | input | 1 | Core has returned from a handler |
| irqValid | output | 1 | A request is offered to the core |
| irqVector | output | 3 | Index of the offered source |
| irqLevel | output | 2 | Level of the offered source |

## Verification
The assertions assume that the core acknowledges only in a cycle where a request is offered. They also assume that return strobes match earlier acknowledges, so the in-service set describes real handler nesting. The bench checks this behaviour directly. It raises `irqAck` only when it expects `irqValid`, except in the one scenario that checks an acknowledge without an offer is ignored. It issues each return strobe as a single pulse after a matching acknowledge, plus one deliberate extra return on an empty set. Request lines are changed only between clock edges and held steady while the outputs are sampled.

// File: rtl/irqArbPkg.sv
package irqArbPkg;
  localparam int NUM_SRC    = 5;
  localparam int NUM_LVL    = 4;
  localparam int LVL_W      = $clog2(NUM_LVL);
  localparam int VEC_W      = $clog2(NUM_SRC);
  localparam int REG_W      = 8;
  localparam int ADDR_W     = 2;
  localparam int GLOBAL_BIT = REG_W - 1;

  localparam logic [ADDR_W-1:0] ADDR_EN     = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRI_LO = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_PRI_HI = 2'd2;

  typedef struct packed {
    logic             push;
    logic [LVL_W-1:0] pushLevel;
    logic             pop;
  } isStrobe_t;
endpackage

// File: rtl/irqArbDatapath.sv
module irqArbDatapath
  import irqArbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  input  logic [NUM_SRC-1:0] irqReq,
  input  isStrobe_t         strobe,
  output logic              candValid,
  output logic [VEC_W-1:0]  candVector,
  output logic [LVL_W-1:0]  candLevel,
  output logic              runValid,
  output logic [LVL_W-1:0]  runLevel
);
  logic                globalEn;
  logic [NUM_SRC-1:0]  srcEn;
  logic [NUM_SRC-1:0]  prioLo;
  logic [NUM_SRC-1:0]  prioHi;
  logic [NUM_LVL-1:0]  inService;
  logic [NUM_LVL-1:0]  inServiceNext;
  logic [NUM_SRC-1:0]  eligible;
  logic [NUM_LVL-1:0]  lvlAny;
  logic [NUM_LVL-1:0][VEC_W-1:0] lvlIdx;
  logic                unusedBits;

  assign unusedBits = ^busWrData[GLOBAL_BIT-1:NUM_SRC];

  // configuration registers and in-service set
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn  <= 1'b0;
      srcEn     <= '0;
      prioLo    <= '0;
      prioHi    <= '0;
      inService <= '0;
    end else begin
      if (busWrEn) begin
        case (busAddr)
          ADDR_EN: begin
            globalEn <= busWrData[GLOBAL_BIT];
            srcEn    <= busWrData[NUM_SRC-1:0];
          end
          ADDR_PRI_LO: prioLo <= busWrData[NUM_SRC-1:0];
          ADDR_PRI_HI: prioHi <= busWrData[NUM_SRC-1:0];
          default: ;
        endcase
      end
      inService <= inServiceNext;
    end
  end

  assign eligible = irqReq & srcEn & {NUM_SRC{globalEn}};

  // per-level winner, lowest index first
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic [NUM_SRC-1:0] hit;
    logic [VEC_W-1:0]   idx;
    always_comb begin
      for (int s = 0; s < NUM_SRC; s++)
        hit[s] = eligible[s] && ({prioHi[s], prioLo[s]} == LVL_W'(l));
    end
    always_comb begin
      idx = '0;
      for (int s = NUM_SRC - 1; s >= 0; s--)
        if (hit[s]) idx = VEC_W'(s);
    end
    assign lvlAny[l] = |hit;
    assign lvlIdx[l] = idx;
  end

  // best level overall
  always_comb begin
    candValid  = 1'b0;
    candVector = '0;
    candLevel  = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (lvlAny[l]) begin
        candValid  = 1'b1;
        candVector = lvlIdx[l];
        candLevel  = LVL_W'(l);
      end
    end
  end

  // highest active in-service level
  always_comb begin
    runLevel = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (inService[l]) runLevel = LVL_W'(l);
  end
  assign runValid = |inService;

  always_comb begin
    inServiceNext = inService;
    if (strobe.pop)  inServiceNext[runLevel]        = 1'b0;
    if (strobe.push) inServiceNext[strobe.pushLevel] = 1'b1;
  end
endmodule

// File: rtl/irqArbControl.sv
module irqArbControl
  import irqArbPkg::*;
(
  input  logic             candValid,
  input  logic [VEC_W-1:0] candVector,
  input  logic [LVL_W-1:0] candLevel,
  input  logic             runValid,
  input  logic [LVL_W-1:0] runLevel,
  input  logic             irqAck,
  input  logic             retStrobe,
  output isStrobe_t        strobe,
  output logic             irqValid,
  output logic [VEC_W-1:0] irqVector,
  output logic [LVL_W-1:0] irqLevel
);
  logic grantOk;

  assign grantOk   = candValid && (!runValid || (candLevel > runLevel));
  assign irqValid  = grantOk;
  assign irqVector = candVector;
  assign irqLevel  = candLevel;

  always_comb begin
    strobe.push      = irqAck && grantOk;
    strobe.pushLevel = candLevel;
    strobe.pop       = retStrobe && runValid;
  end
endmodule

// File: rtl/irqArbiter.sv
module irqArbiter
  import irqArbPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic              irqAck,
  input  logic              retStrobe,
  output logic              irqValid,
  output logic [VEC_W-1:0]  irqVector,
  output logic [LVL_W-1:0]  irqLevel
);
  isStrobe_t        strobe;
  logic             candValid;
  logic [VEC_W-1:0] candVector;
  logic [LVL_W-1:0] candLevel;
  logic             runValid;
  logic [LVL_W-1:0] runLevel;

  irqArbDatapath u_dp (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .irqReq(irqReq), .strobe(strobe),
    .candValid(candValid), .candVector(candVector), .candLevel(candLevel),
    .runValid(runValid), .runLevel(runLevel)
  );

  irqArbControl u_ctl (
    .candValid(candValid), .candVector(candVector), .candLevel(candLevel),
    .runValid(runValid), .runLevel(runLevel), .irqAck(irqAck),
    .retStrobe(retStrobe), .strobe(strobe), .irqValid(irqValid),
    .irqVector(irqVector), .irqLevel(irqLevel)
  );
endmodule

// File: rtl/irqArbChecker.sv
module irqArbChecker
  import irqArbPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] irqReq,
  input logic               irqAck,
  input logic               retStrobe,
  input logic               irqValid,
  input logic [VEC_W-1:0]   irqVector,
  input logic [LVL_W-1:0]   irqLevel,
  input logic [NUM_LVL-1:0] inService,
  input logic               runValid,
  input logic [LVL_W-1:0]   runLevel
);
  p_strict_preempt_r3: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && runValid) |-> (irqLevel > runLevel));

  p_top_level_locks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (runValid && runLevel == LVL_W'(NUM_LVL - 1)) |-> !irqValid);

  p_offer_is_requested_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> irqReq[irqVector]);

  p_vector_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> (irqVector < VEC_W'(NUM_SRC)));

  p_ack_marks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && irqAck) |=> inService[$past(irqLevel)]);

  p_ret_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (retStrobe && !irqAck && runValid) |=> !inService[$past(runLevel)]);

  p_idle_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!irqValid && !retStrobe) |=> $stable(inService));
endmodule

bind irqArbiter irqArbChecker u_chk (
  .clk(clk), .rstN(rstN), .irqReq(irqReq), .irqAck(irqAck),
  .retStrobe(retStrobe), .irqValid(irqValid), .irqVector(irqVector),
  .irqLevel(irqLevel), .inService(u_dp.inService),
  .runValid(u_dp.runValid), .runLevel(u_dp.runLevel)
);

// File: tb/sim_irqArbiter.sv
`timescale 1ns/1ps
module sim_irqArbiter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [4:0] irqReq = '0;
  logic       irqAck = 1'b0;
  logic       retStrobe = 1'b0;
  logic       irqValid;
  logic [2:0] irqVector;
  logic [1:0] irqLevel;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irqArbiter u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .irqReq(irqReq), .irqAck(irqAck),
    .retStrobe(retStrobe), .irqValid(irqValid), .irqVector(irqVector),
    .irqLevel(irqLevel)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expectOut(string tag, bit v, int vec, int lvl);
    #1;
    chk({tag, " valid"}, int'(irqValid), int'(v));
    if (v) begin
      chk({tag, " vector"}, int'(irqVector), vec);
      chk({tag, " level"}, int'(irqLevel), lvl);
    end
  endtask

  task automatic resetDut();
    irqReq = '0; irqAck = 0; retStrobe = 0; busWrEn = 0;
    rstN = 0; tick(); tick(); rstN = 1; tick();
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    busWrEn = 1; busAddr = a; busWrData = d; tick(); busWrEn = 0;
  endtask

  task automatic ack();
    irqAck = 1; tick(); irqAck = 0;
  endtask

  task automatic ret();
    retStrobe = 1; tick(); retStrobe = 0;
  endtask

  task automatic testReset();
    resetDut();
    irqReq = 5'b11111;
    expectOut("R6 reset no offer", 0, 0, 0);
    wr(2'd0, 8'h9F);
    expectOut("R9 all level0 int0 wins", 1, 0, 0);
    irqReq = 5'b11110;
    expectOut("R9 timer0 next", 1, 1, 0);
    irqReq = 5'b11100;
    expectOut("R9 int1 next", 1, 2, 0);
    irqReq = 5'b10000;
    expectOut("R1 serial index", 1, 4, 0);
  endtask

  task automatic testEnables();
    resetDut();
    wr(2'd0, 8'h1F);
    irqReq = 5'b00001;
    expectOut("R7 global off", 0, 0, 0);
    wr(2'd0, 8'h9E);
    expectOut("R7 source off", 0, 0, 0);
    irqReq = 5'b00011;
    expectOut("R7 enabled timer0", 1, 1, 0);
  endtask

  task automatic testLevels();
    resetDut();
    wr(2'd0, 8'h9F);
    wr(2'd1, 8'h10);
    wr(2'd2, 8'h08);
    irqReq = 5'b11111;
    expectOut("R5 timer1 level2 first", 1, 3, 2);
    irqReq = 5'b10111;
    expectOut("R2 serial low bit level1", 1, 4, 1);
    wr(2'd2, 8'h10);
    irqReq = 5'b11111;
    expectOut("R2 serial both bits level3", 1, 4, 3);
  endtask

  task automatic testNesting();
    resetDut();
    wr(2'd0, 8'h9F);
    wr(2'd1, 8'h12);
    wr(2'd2, 8'h14);
    irqReq = 5'b00001;
    expectOut("R8 int0 offered", 1, 0, 0);
    ack();
    expectOut("R3 same level held", 0, 0, 0);
    irqReq = 5'b00011;
    expectOut("R3 higher preempts", 1, 1, 1);
    ack();
    irqReq = 5'b00111;
    expectOut("R3 level2 preempts", 1, 2, 2);
    ack();
    irqReq = 5'b10111;
    expectOut("R3 level3 preempts", 1, 4, 3);
    ack();
    irqReq = 5'b11111;
    expectOut("R4 level3 locks", 0, 0, 0);
    ret();
    expectOut("R8 ret pops level3", 1, 4, 3);
    irqReq = 5'b00111;
    expectOut("R3 level2 held at level2", 0, 0, 0);
    ret();
    expectOut("R8 ret pops level2", 1, 2, 2);
    ret();
    ret();
    irqReq = 5'b00001;
    expectOut("R8 set empty", 1, 0, 0);
    ret();
    expectOut("R8 ret on empty no effect", 1, 0, 0);
  endtask

  task automatic testIgnored();
    resetDut();
    wr(2'd0, 8'h9F);
    irqAck = 1; tick(); irqAck = 0;
    irqReq = 5'b00001;
    expectOut("R10 stray ack ignored", 1, 0, 0);
    wr(2'd3, 8'h00);
    expectOut("R10 addr3 ignored", 1, 0, 0);
  endtask

  initial begin
    testReset();
    testEnables();
    testLevels();
    testNesting();
    testIgnored();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule